// File: doc/BRIEF.md
# DMT Superframe Multiplexer and Framer

This block builds per-symbol data frames for a discrete multitone transmitter. Several byte-wide bearer channels feed it. At each symbol-rate strobe it assembles one frame for the fast path and one for the interleaved path. Each bearer channel is assigned to one of the two paths and gives a fixed number of bytes to every frame. Every frame on a path begins with one overhead byte. The overhead content is only placeholder bytes here, except for the CRC byte.

Frames are counted in superframes. A superframe holds 68 data frames and then one synchronisation frame. The synchronisation frame has the same length as a data frame but carries only fill bytes. Each path keeps a running CRC-8 over its superframe. That CRC is reported on a status port and is also inserted as the overhead byte of the next superframe's first frame. Software writes the channel quotas and path assignments while the run bit is low. Raising the run bit starts framing at frame 0.

The bearer inputs and both framed outputs are valid/ready streams. When an output path is back-pressured, its frame generation stalls, and so do the bearer reads that feed that path. A bearer channel that has no byte ready when its slot is generated does not stall the frame. It is zero-filled and flagged instead.

Top module: `dmt_sf_framer`

## Requirements
- R1: From a rising edge of `run`, accepted frames are numbered 0 to 68 and then wrap to 0. Frame 68 is the synchronisation frame. `*_frame_start` marks the first byte of every frame. `*_sf_start` also marks the first byte of frame 0.
- R2: A `symbol_strobe` starts one frame on both paths only when `run` is high and both paths have generated every byte of the previous frame. Otherwise the strobe is ignored: no bytes are produced and the frame number does not advance.
- R3: A data frame on a path is one overhead byte followed by the bytes of the bearer channels assigned to that path, in ascending channel index. `cfg_intl`=0 assigns a channel to the fast path and 1 to the interleaved path. Each channel contributes exactly its quota of bytes, taken in arrival order.
- R4: The overhead byte of frame 0 is the CRC of the previous superframe on that path. It is 0x00 for the first superframe after `run` rises. The overhead byte of frames 1 to 67 is 0xA5.
- R5: The synchronisation frame has the same length as a data frame. Every byte of it is 0x3C, and it consumes no bearer byte.
- R6: The path CRC has these properties:
  - polynomial x^8+x^4+x^3+x^2+1 (0x1D), initial value 0, MSB first, no final inversion;
  - it covers every byte of a superframe on that path except the frame-0 overhead byte;
  - it appears on `fast_crc`/`intl_crc` once the last byte of the synchronisation frame has been generated;
  - it reads 0 after reset or while `run` is low.
- R7: If bearer channel c has `ch_valid[c]` low when its byte is generated, the byte is sent as 0x00 and `underrun[c]` is set. The flag stays set until reset.
- R8: A configuration write (`cfg_we` with `cfg_ch`, `cfg_quota`, `cfg_intl`) is accepted only while `run` is low. Writes while `run` is high change nothing.
- R9: While `*_valid` is high and `*_ready` is low, that output holds its valid, data and markers unchanged. A byte moves when both are high.
- R10: After reset, both outputs are idle, `ch_ready` is low, `underrun` is zero and both CRC ports are zero. Dropping `run` abandons framing, and the next rise restarts at frame 0.
- R11: `ch_ready[c]` is high only in a cycle in which its path generates a byte for channel c. Over a frame, each channel gives up exactly its quota of bytes (none in a synchronisation frame).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Framing enable; configuration is writable only while low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel index of the write |
| cfg_quota | input | QW | Bytes per frame from that channel |
| cfg_intl | input | 1 | Path of that channel: 0 fast, 1 interleaved |
| symbol_strobe | input | 1 | Symbol-rate pulse that requests a frame |
| ch_valid | input | NCH | Bearer byte valid, one bit per channel |
| ch_data | input | NCH*8 | Bearer bytes, channel c in bits 8c+7..8c |
| ch_ready | output | NCH | Bearer byte taken, one bit per channel |
| fast_ready | input | 1 | Fast output ready |
| fast_valid | output | 1 | Fast output valid |
| fast_data | output | 8 | Fast output byte |
| fast_frame_start | output | 1 | First byte of a frame on the fast path |
| fast_sf_start | output | 1 | First byte of a superframe on the fast path |
| intl_ready | input | 1 | Interleaved output ready |
| intl_valid | output | 1 | Interleaved output valid |
| intl_data | output | 8 | Interleaved output byte |
| intl_frame_start | output | 1 | First byte of a frame on the interleaved path |
| intl_sf_start | output | 1 | First byte of a superframe on the interleaved path |
| fast_crc | output | 8 | CRC of the last completed superframe, fast path |
| intl_crc | output | 8 | CRC of the last completed superframe, interleaved path |
| underrun | output | NCH | Sticky per-channel underrun flags |

## Verification
The assertions check on every cycle:
- that a stalled output holds still;
- that the frame number never passes the synchronisation frame;
- that underrun flags never clear;
- that configuration stays frozen while running;
- that an accepted strobe makes both paths busy;
- that a superframe marker always comes with a frame marker.

The bench's scenarios are needed for the rest:
- byte order and content across a full 69-frame superframe;
- the CRC carried into the next frame 0;
- zero-fill on a starved channel;
- ignored back-to-back and idle strobes;
- restarting at frame 0 after `run` is toggled with a new configuration.

// File: rtl/dmt_sf_pkg.sv
package dmt_sf_pkg;
  localparam logic [7:0] OVH_FILL  = 8'hA5;
  localparam logic [7:0] SYNC_FILL = 8'h3C;
  localparam logic [7:0] CRC_POLY  = 8'h1D;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] din);
    logic [7:0] r;
    r = crc ^ din;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/dmt_sf_cfg.sv
module dmt_sf_cfg #(
  parameter int NCH = 3,
  parameter int QW  = 4,
  parameter int CHW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              we,
  input  logic [CHW-1:0]    ch,
  input  logic [QW-1:0]     quota,
  input  logic              intl,
  output logic [NCH*QW-1:0] quota_flat,
  output logic [NCH-1:0]    intl_map
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        quota_flat[c*QW +: QW] <= '0;
        intl_map[c]            <= 1'b0;
      end else if (we && !run && (int'(ch) == c)) begin
        quota_flat[c*QW +: QW] <= quota;
        intl_map[c]            <= intl;
      end
    end
  end

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(quota_flat) && $stable(intl_map)));
endmodule

// File: rtl/dmt_sf_path.sv
module dmt_sf_path
  import dmt_sf_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int QW   = 4,
  parameter int CHW  = 2,
  parameter int PATH = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic              is_sf0,
  input  logic              is_sync,
  input  logic [NCH*QW-1:0] quota_flat,
  input  logic [NCH-1:0]    intl_map,
  input  logic [NCH-1:0]    ch_valid,
  input  logic [NCH*8-1:0]  ch_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_fs,
  output logic              out_sfs,
  output logic [NCH-1:0]    ch_take,
  output logic [NCH-1:0]    urun_set,
  output logic              busy,
  output logic [7:0]        crc_o
);
  logic [QW-1:0]  quota_a [NCH];
  logic [7:0]     data_a  [NCH];
  logic [NCH-1:0] elig;

  logic           hdr, sync_f, sf0_f;
  logic [CHW-1:0] cur;
  logic [QW-1:0]  cnt;
  logic [7:0]     crc_run, crc_last, crc_nxt, gen_byte;
  logic           first_ok, after_ok, last, gen;
  logic [CHW-1:0] first_idx, after_idx;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      quota_a[c] = quota_flat[c*QW +: QW];
      data_a[c]  = ch_data[c*8 +: 8];
      elig[c]    = (intl_map[c] == 1'(PATH)) && (quota_flat[c*QW +: QW] != '0);
    end
  end

  // next eligible channel from the start, and after the current one
  always_comb begin
    first_ok  = 1'b0;
    first_idx = '0;
    after_ok  = 1'b0;
    after_idx = '0;
    for (int c = 0; c < NCH; c++) begin
      if (elig[c] && !first_ok) begin
        first_ok  = 1'b1;
        first_idx = CHW'(c);
      end
      if (elig[c] && !after_ok && (c > int'(cur))) begin
        after_ok  = 1'b1;
        after_idx = CHW'(c);
      end
    end
  end

  assign gen = busy && (!out_valid || out_ready);

  always_comb begin
    if (sync_f)   gen_byte = SYNC_FILL;
    else if (hdr) gen_byte = sf0_f ? crc_last : OVH_FILL;
    else          gen_byte = ch_valid[cur] ? data_a[cur] : 8'h00;
  end

  assign last    = hdr ? !first_ok : ((cnt == QW'(1)) && !after_ok);
  assign crc_nxt = crc8_step(crc_run, gen_byte);
  assign crc_o   = crc_last;

  for (genvar c = 0; c < NCH; c++) begin : g_take
    assign ch_take[c]  = gen && !hdr && !sync_f && (int'(cur) == c);
    assign urun_set[c] = ch_take[c] && !ch_valid[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      busy      <= 1'b0;
      hdr       <= 1'b0;
      sync_f    <= 1'b0;
      sf0_f     <= 1'b0;
      cur       <= '0;
      cnt       <= '0;
      crc_run   <= '0;
      crc_last  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_fs    <= 1'b0;
      out_sfs   <= 1'b0;
    end else begin
      if (start && !busy) begin
        busy   <= 1'b1;
        hdr    <= 1'b1;
        sync_f <= is_sync;
        sf0_f  <= is_sf0;
        if (is_sf0) crc_run <= '0;
      end
      if (gen) begin
        out_valid <= 1'b1;
        out_data  <= gen_byte;
        out_fs    <= hdr;
        out_sfs   <= hdr && sf0_f;
        if (!(hdr && sf0_f)) crc_run <= crc_nxt;
        if (last) begin
          busy <= 1'b0;
          if (sync_f) crc_last <= crc_nxt;
        end
        if (hdr) begin
          hdr <= 1'b0;
          cur <= first_idx;
          cnt <= quota_a[first_idx];
        end else if (cnt == QW'(1)) begin
          cur <= after_idx;
          cnt <= quota_a[after_idx];
        end else begin
          cnt <= cnt - QW'(1);
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n || !run)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_fs) && $stable(out_sfs)));

  assert_sf_marks_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sfs) |-> out_fs);
endmodule

// File: rtl/dmt_sf_framer.sv
module dmt_sf_framer
  import dmt_sf_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int QW          = 4,
  parameter int DATA_FRAMES = 68,
  localparam int CHW        = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int FCW        = $clog2(DATA_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_we,
  input  logic [CHW-1:0]   cfg_ch,
  input  logic [QW-1:0]    cfg_quota,
  input  logic             cfg_intl,
  input  logic             symbol_strobe,
  input  logic [NCH-1:0]   ch_valid,
  input  logic [NCH*8-1:0] ch_data,
  output logic [NCH-1:0]   ch_ready,
  input  logic             fast_ready,
  output logic             fast_valid,
  output logic [7:0]       fast_data,
  output logic             fast_frame_start,
  output logic             fast_sf_start,
  input  logic             intl_ready,
  output logic             intl_valid,
  output logic [7:0]       intl_data,
  output logic             intl_frame_start,
  output logic             intl_sf_start,
  output logic [7:0]       fast_crc,
  output logic [7:0]       intl_crc,
  output logic [NCH-1:0]   underrun
);
  logic [NCH*QW-1:0] quota_flat;
  logic [NCH-1:0]    intl_map;
  logic [FCW-1:0]    fidx;
  logic              accept;
  logic [1:0]        p_rdy, p_ov, p_fs, p_sfs, p_busy;
  logic [7:0]        p_od  [2];
  logic [7:0]        p_crc [2];
  logic [NCH-1:0]    p_take [2];
  logic [NCH-1:0]    p_urun [2];

  dmt_sf_cfg #(.NCH(NCH), .QW(QW), .CHW(CHW)) cfg_i (
    .clk(clk), .rst_n(rst_n), .run(run), .we(cfg_we), .ch(cfg_ch),
    .quota(cfg_quota), .intl(cfg_intl), .quota_flat(quota_flat), .intl_map(intl_map)
  );

  assign accept = run && symbol_strobe && (p_busy == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)  fidx <= '0;
    else if (accept)     fidx <= (fidx == FCW'(DATA_FRAMES)) ? '0 : fidx + FCW'(1);
  end

  assign p_rdy = {intl_ready, fast_ready};

  for (genvar p = 0; p < 2; p++) begin : g_path
    dmt_sf_path #(.NCH(NCH), .QW(QW), .CHW(CHW), .PATH(p)) path_i (
      .clk(clk), .rst_n(rst_n), .run(run), .start(accept),
      .is_sf0(fidx == '0), .is_sync(fidx == FCW'(DATA_FRAMES)),
      .quota_flat(quota_flat), .intl_map(intl_map),
      .ch_valid(ch_valid), .ch_data(ch_data), .out_ready(p_rdy[p]),
      .out_valid(p_ov[p]), .out_data(p_od[p]), .out_fs(p_fs[p]), .out_sfs(p_sfs[p]),
      .ch_take(p_take[p]), .urun_set(p_urun[p]), .busy(p_busy[p]), .crc_o(p_crc[p])
    );
  end

  assign ch_ready = p_take[0] | p_take[1];

  always_ff @(posedge clk) begin
    if (!rst_n) underrun <= '0;
    else        underrun <= underrun | p_urun[0] | p_urun[1];
  end

  assign fast_valid       = p_ov[0];
  assign fast_data        = p_od[0];
  assign fast_frame_start = p_fs[0];
  assign fast_sf_start    = p_sfs[0];
  assign intl_valid       = p_ov[1];
  assign intl_data        = p_od[1];
  assign intl_frame_start = p_fs[1];
  assign intl_sf_start    = p_sfs[1];
  assign fast_crc         = p_crc[0];
  assign intl_crc         = p_crc[1];

  assert_frame_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fidx <= FCW'(DATA_FRAMES));

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((underrun & $past(underrun)) == $past(underrun)));

  assert_strobe_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept) |=> (p_busy == 2'b11 || !run));
endmodule

// File: tb/dmt_sf_framer_tb_top.sv
module dmt_sf_framer_tb_top;
  localparam int NCH = 3;
  localparam int QW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [QW-1:0] cfg_quota = '0;
  logic cfg_intl = 1'b0;
  logic symbol_strobe = 1'b0;
  logic [NCH-1:0] ch_valid;
  logic [NCH*8-1:0] ch_data;
  logic [NCH-1:0] ch_ready;
  logic fast_ready = 1'b1, intl_ready = 1'b1;
  logic fast_valid, fast_frame_start, fast_sf_start;
  logic intl_valid, intl_frame_start, intl_sf_start;
  logic [7:0] fast_data, intl_data, fast_crc, intl_crc;
  logic [NCH-1:0] underrun;

  always #2.5 clk = ~clk;

  dmt_sf_framer #(.NCH(NCH), .QW(QW)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_quota(cfg_quota), .cfg_intl(cfg_intl), .symbol_strobe(symbol_strobe),
    .ch_valid(ch_valid), .ch_data(ch_data), .ch_ready(ch_ready),
    .fast_ready(fast_ready), .fast_valid(fast_valid), .fast_data(fast_data),
    .fast_frame_start(fast_frame_start), .fast_sf_start(fast_sf_start),
    .intl_ready(intl_ready), .intl_valid(intl_valid), .intl_data(intl_data),
    .intl_frame_start(intl_frame_start), .intl_sf_start(intl_sf_start),
    .fast_crc(fast_crc), .intl_crc(intl_crc), .underrun(underrun)
  );

  typedef struct packed { logic [7:0] d; logic fs; logic sfs; logic [3:0] tag; } exp_t;
  exp_t q_f[$];
  exp_t q_i[$];

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // bench sources
  logic [7:0] src_cnt [NCH];
  logic [NCH-1:0] src_en;
  logic [NCH-1:0] took;
  bit stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int m_frame = 0;
  int m_quota [NCH];
  int m_intl [NCH];
  logic [7:0] m_cnt [NCH];
  logic [7:0] m_crc_run [2];
  logic [7:0] m_crc_prev [2];

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ch_valid[c] = src_en[c];
      ch_data[c*8 +: 8] = 8'(c * 64) + src_cnt[c];
    end
  end

  function automatic string tname(input logic [3:0] t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input bit ok, input logic [3:0] tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tname(tag), act, exp, $time);
    end
  endtask

  function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h1D) : (r << 1);
    return r;
  endfunction

  function automatic void push(input int p, input logic [7:0] d, input logic fs,
                               input logic sfs, input logic [3:0] tag);
    exp_t e;
    e.d = d; e.fs = fs; e.sfs = sfs; e.tag = tag;
    if (p == 0) q_f.push_back(e); else q_i.push_back(e);
  endfunction

  function automatic void model_frame();
    bit sf0, sy;
    logic [7:0] b;
    sf0 = (m_frame == 0);
    sy  = (m_frame == 68);
    for (int p = 0; p < 2; p++) begin
      b = sy ? 8'h3C : (sf0 ? m_crc_prev[p] : 8'hA5);
      push(p, b, 1'b1, sf0, sy ? 4'd5 : 4'd4);
      m_crc_run[p] = sf0 ? 8'h00 : crc_upd(m_crc_run[p], b);
      for (int c = 0; c < NCH; c++) begin
        if (m_intl[c] == p) begin
          for (int k = 0; k < m_quota[c]; k++) begin
            if (sy) b = 8'h3C;
            else if (src_en[c]) begin b = 8'(c * 64) + m_cnt[c]; m_cnt[c]++; end
            else b = 8'h00;
            push(p, b, 1'b0, 1'b0, sy ? 4'd5 : (src_en[c] ? 4'd3 : 4'd7));
            m_crc_run[p] = crc_upd(m_crc_run[p], b);
          end
        end
      end
      if (sy) m_crc_prev[p] = m_crc_run[p];
    end
    m_frame = (m_frame == 68) ? 0 : m_frame + 1;
  endfunction

  // compare on every clock, away from the active edge
  logic pst_f = 0, pst_i = 0;
  logic [7:0] pd_f, pd_i;
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (pst_f) chk(fast_valid && fast_data == pd_f, 9, fast_data, pd_f);
      if (pst_i) chk(intl_valid && intl_data == pd_i, 9, intl_data, pd_i);
      if (fast_valid && fast_ready) begin
        if (q_f.size() == 0) chk(0, 2, fast_data, 0);
        else begin
          e = q_f.pop_front();
          chk(fast_data == e.d, e.tag, fast_data, e.d);
          chk({fast_frame_start, fast_sf_start} == {e.fs, e.sfs}, 1,
              {fast_frame_start, fast_sf_start}, {e.fs, e.sfs});
        end
      end
      if (intl_valid && intl_ready) begin
        if (q_i.size() == 0) chk(0, 2, intl_data, 0);
        else begin
          e = q_i.pop_front();
          chk(intl_data == e.d, e.tag, intl_data, e.d);
          chk({intl_frame_start, intl_sf_start} == {e.fs, e.sfs}, 1,
              {intl_frame_start, intl_sf_start}, {e.fs, e.sfs});
        end
      end
    end
    pst_f = fast_valid && !fast_ready; pd_f = fast_data;
    pst_i = intl_valid && !intl_ready; pd_i = intl_data;
    took = ch_valid & ch_ready;
  end

  always @(posedge clk) begin
    #1;
    for (int c = 0; c < NCH; c++) if (took[c]) src_cnt[c]++;
    took = '0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    fast_ready = stall_mode ? lfsr[0] : 1'b1;
    intl_ready = stall_mode ? lfsr[3] : 1'b1;
  end

  task automatic cfg_write(input int ch, input int q, input int il);
    @(posedge clk); #1;
    cfg_we = 1; cfg_ch = 2'(ch); cfg_quota = QW'(q); cfg_intl = il[0];
    if (!run) begin m_quota[ch] = q; m_intl[ch] = il; end
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic drain();
    while (q_f.size() > 0 || q_i.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_frame(input bit twice);
    @(posedge clk); #1;
    symbol_strobe = 1;
    if (run) model_frame();
    @(posedge clk); #1;
    if (!twice) symbol_strobe = 0;
    else begin @(posedge clk); #1; symbol_strobe = 0; end
    drain();
    for (int c = 0; c < NCH; c++) chk(src_cnt[c] == m_cnt[c], 11, src_cnt[c], m_cnt[c]);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      src_cnt[c] = 0; m_cnt[c] = 0; m_quota[c] = 0; m_intl[c] = 0;
    end
    m_crc_prev[0] = 0; m_crc_prev[1] = 0; m_crc_run[0] = 0; m_crc_run[1] = 0;
    src_en = '1;
    took = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!fast_valid && !intl_valid, 10, {fast_valid, intl_valid}, 0);
    chk(ch_ready == 0, 10, ch_ready, 0);
    chk(underrun == 0, 10, underrun, 0);
    chk(fast_crc == 0 && intl_crc == 0, 10, {fast_crc, intl_crc}, 0);

    cfg_write(0, 3, 0);
    cfg_write(1, 2, 1);
    cfg_write(2, 1, 0);
    @(posedge clk); #1 run = 1;

    for (int f = 0; f < 72; f++) begin
      if (f == 10) cfg_write(0, 7, 1);           // R8: ignored while running
      stall_mode = (f >= 30 && f < 50);         // R9: back-pressure
      if (f == 40) src_en[2] = 0;               // R7: starve channel 2
      if (f == 43) begin
        chk(underrun == 3'b100, 7, underrun, 3'b100);
        src_en[2] = 1;
      end
      do_frame(f == 20);                        // R2: second strobe while busy
      if (f == 68) begin                        // R6: CRC reported after sync frame
        chk(fast_crc == m_crc_prev[0], 6, fast_crc, m_crc_prev[0]);
        chk(intl_crc == m_crc_prev[1], 6, intl_crc, m_crc_prev[1]);
      end
    end
    chk(underrun == 3'b100, 7, underrun, 3'b100);

    // R10 / R2: run low stops framing; strobes ignored
    @(posedge clk); #1 run = 0;
    do_frame(0);
    repeat (10) @(negedge clk);
    chk(fast_crc == 0 && intl_crc == 0, 6, {fast_crc, intl_crc}, 0);
    m_frame = 0; m_crc_prev[0] = 0; m_crc_prev[1] = 0;
    cfg_write(1, 4, 0);                         // R8: accepted while stopped
    cfg_write(0, 2, 1);
    @(posedge clk); #1 run = 1;
    for (int f = 0; f < 3; f++) do_frame(0);    // R10: restarts at frame 0

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R2 watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule